// File: doc/BRIEF.md
# Machine ISA Capability Register

This block is the machine-mode control and status register that tells software two things: the native integer register width, and which major instruction-set extensions the hart carries. It answers at CSR address 0x301. Each extension has one bit, and the bit's index is its letter's position in the alphabet, with A at bit 0. The two most significant bits of the register hold the width code. Bit G is a summary bit and is never stored.

Parameters set whether the register exists, which extensions are built into the core, and which of those extensions software may switch off and on again. The only writable bits are those of extensions that are both implemented and declared mutable. A write that would leave the floating-point bits in an inconsistent state is legalized: F, D and Q keep their earlier values, and the rest of the same write still takes effect.

The block drives one enable line per letter to the decode logic. When software clears a mutable bit, that extension's line drops, and decode can then trap the extension's instructions as illegal.

Top module: `isa_caps_csr`

## Requirements
- R1: After synchronous reset, every letter bit reads 1 when its extension is implemented and 0 otherwise. Bit 8 (I) always reads 1. The width code in the top two bits reads 2'b01 when XW=32.
- R2: Writes do not change a bit unless its extension is both implemented and mutable. Unimplemented letters, unassigned bits, the width code and bit 8 (I) are all unchanged by writes.
- R3: A write to address 0x301 with csr_we high updates each writable letter bit on the next rising clock edge. Without such a write the stored value holds.
- R4: A write that would leave bit 5 (F) at 0 while bit 3 (D) is 1 is illegal. On such a write bits 5, 3 and 16 (F, D, Q) keep their previous values, and the other writable bits still update.
- R5: A write that would leave bit 16 (Q) at 1 while F or D is 0 is illegal. It is handled in the same way as in R4.
- R6: Bit 6 (G) is read-only. It reads as the AND of bits 0, 12, 5 and 3 (A, M, F, D).
- R7: With PRESENT=0 the register reads all zeros and ignores every write. Each ext_en bit then stays at its implemented value.
- R8: A write to any address other than 0x301 leaves the register unchanged. A read at any other address returns zero.
- R9: Each ext_en bit equals the letter bit at the same index of the current value. Clearing a mutable bit therefore drops that extension's enable in the same cycle that the read value changes.
- R10: When XW=64 the width code in bits 63:62 reads 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 12 | CSR address for both read and write |
| csr_we | input | 1 | Write enable, sampled on the rising edge |
| csr_wdata | input | XW | Write data |
| csr_rdata | output | XW | Combinational read data for csr_addr |
| ext_en | output | 26 | Per-letter extension enable to decode |

## Verification
Stored state is visible on csr_rdata combinationally. A corrupted bit therefore shows up on the read port in the same cycle, and on ext_en in that cycle too. A failed legalization is caught from the first cycle after the bad write: the register then holds a forbidden F/D/Q combination, or it has dropped the unrelated fields of that write. A read-only bit that moves shows up as a change in the read value even though no qualifying write happened.

// File: rtl/isa_caps_pkg.sv
package isa_caps_pkg;

    localparam int NLET = 26;

    localparam int L_A = 0;
    localparam int L_B = 1;
    localparam int L_C = 2;
    localparam int L_D = 3;
    localparam int L_F = 5;
    localparam int L_G = 6;
    localparam int L_H = 7;
    localparam int L_I = 8;
    localparam int L_M = 12;
    localparam int L_Q = 16;
    localparam int L_S = 18;
    localparam int L_U = 20;
    localparam int L_V = 21;

    localparam logic [11:0] ISA_CSR_ADDR = 12'h301;

    typedef logic [NLET-1:0] letter_vec_t;

    typedef struct packed {
        logic q;
        logic f;
        logic d;
    } fp_trio_t;

    function automatic letter_vec_t bit_of(int idx);
        letter_vec_t v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    // Replace the summary position with the AND of its four members.
    function automatic letter_vec_t fold_summary(letter_vec_t v);
        letter_vec_t r;
        r = v;
        r[L_G] = v[L_A] & v[L_M] & v[L_F] & v[L_D];
        return r;
    endfunction

    function automatic fp_trio_t fp_pick(letter_vec_t v);
        fp_trio_t t;
        t.q = v[L_Q];
        t.f = v[L_F];
        t.d = v[L_D];
        return t;
    endfunction

    function automatic logic fp_trio_legal(fp_trio_t t);
        logic bad_fd;
        logic bad_q;
        bad_fd = !t.f && t.d;
        bad_q  = t.q && !(t.f && t.d);
        return !(bad_fd || bad_q);
    endfunction

    function automatic logic [1:0] width_code(int xw);
        return (xw == 64) ? 2'b10 : (xw == 128) ? 2'b11 : 2'b01;
    endfunction

endpackage

// File: rtl/isa_caps_merge.sv
module isa_caps_merge
    import isa_caps_pkg::*;
#(
    parameter letter_vec_t WMASK = '0
) (
    input  letter_vec_t cur,
    input  letter_vec_t wr_letters,
    output letter_vec_t nxt,
    output logic        reject
);

    letter_vec_t cand;
    fp_trio_t    cand_fp;
    fp_trio_t    keep_fp;

    always_comb begin
        cand    = (wr_letters & WMASK) | (cur & ~WMASK);
        cand_fp = fp_pick(cand);
        keep_fp = fp_pick(cur);
        reject  = !fp_trio_legal(cand_fp);
        nxt     = cand;
        if (reject) begin
            nxt[L_F] = keep_fp.f;
            nxt[L_D] = keep_fp.d;
            nxt[L_Q] = keep_fp.q;
        end
    end

endmodule

// File: rtl/isa_caps_store.sv
module isa_caps_store
    import isa_caps_pkg::*;
#(
    parameter letter_vec_t RST_VAL = '0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  letter_vec_t nxt,
    output letter_vec_t cur
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= RST_VAL;
        end else if (load) begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/isa_caps_view.sv
module isa_caps_view
    import isa_caps_pkg::*;
#(
    parameter int          XW        = 32,
    parameter bit          PRESENT   = 1'b1,
    parameter letter_vec_t FIXED_EN  = '0
) (
    input  logic [11:0]   rd_addr,
    input  letter_vec_t   cur,
    output logic [XW-1:0] rdata,
    output letter_vec_t   ext_en
);

    localparam int PAD = XW - 2 - NLET;

    letter_vec_t shown;
    logic [XW-1:0] word;

    assign shown = fold_summary(cur);

    generate
        if (PAD > 0) begin : g_pad
            assign word = {width_code(XW), {PAD{1'b0}}, shown};
        end else begin : g_nopad
            assign word = {width_code(XW), shown};
        end
    endgenerate

    generate
        if (PRESENT) begin : g_live
            assign rdata  = (rd_addr == ISA_CSR_ADDR) ? word : '0;
            assign ext_en = shown;
        end else begin : g_absent
            assign rdata  = '0;
            assign ext_en = FIXED_EN;
        end
    endgenerate

endmodule

// File: rtl/isa_caps_csr.sv
module isa_caps_csr
    import isa_caps_pkg::*;
#(
    parameter int          XW        = 32,
    parameter bit          PRESENT   = 1'b1,
    parameter letter_vec_t IMPL_MASK = bit_of(L_A) | bit_of(L_C) | bit_of(L_D) |
                                       bit_of(L_F) | bit_of(L_I) | bit_of(L_M) |
                                       bit_of(L_S) | bit_of(L_U),
    parameter letter_vec_t MUT_MASK  = bit_of(L_A) | bit_of(L_C) | bit_of(L_D) |
                                       bit_of(L_F)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [11:0]   csr_addr,
    input  logic          csr_we,
    input  logic [XW-1:0] csr_wdata,
    output logic [XW-1:0] csr_rdata,
    output letter_vec_t   ext_en
);

    localparam letter_vec_t IMPL_EFF = (IMPL_MASK | bit_of(L_I)) & ~bit_of(L_G);
    localparam letter_vec_t WMASK    = PRESENT ? (IMPL_EFF & MUT_MASK & ~bit_of(L_I)) : '0;
    localparam letter_vec_t RST_VAL  = PRESENT ? IMPL_EFF : '0;
    localparam letter_vec_t FIXED_EN = fold_summary(IMPL_EFF);
    localparam letter_vec_t RD_MOVE  = WMASK | bit_of(L_G);

    letter_vec_t cur_bits;
    letter_vec_t nxt_bits;
    logic        fp_reject;
    logic        wr_hit;

    assign wr_hit = PRESENT && csr_we && (csr_addr == ISA_CSR_ADDR);

    isa_caps_merge #(.WMASK(WMASK)) u_merge (
        .cur        (cur_bits),
        .wr_letters (csr_wdata[NLET-1:0]),
        .nxt        (nxt_bits),
        .reject     (fp_reject)
    );

    isa_caps_store #(.RST_VAL(RST_VAL)) u_store (
        .clk  (clk),
        .rst  (rst),
        .load (wr_hit),
        .nxt  (nxt_bits),
        .cur  (cur_bits)
    );

    isa_caps_view #(.XW(XW), .PRESENT(PRESENT), .FIXED_EN(FIXED_EN)) u_view (
        .rd_addr (csr_addr),
        .cur     (cur_bits),
        .rdata   (csr_rdata),
        .ext_en  (ext_en)
    );

endmodule

// File: rtl/isa_caps_csr_chk.sv
module isa_caps_csr_chk
    import isa_caps_pkg::*;
#(
    parameter int          XW      = 32,
    parameter bit          PRESENT = 1'b1,
    parameter letter_vec_t RD_MOVE = '0
) (
    input logic          clk,
    input logic          rst,
    input logic [11:0]   csr_addr,
    input logic [XW-1:0] csr_rdata,
    input letter_vec_t   ext_en,
    input letter_vec_t   cur,
    input logic          wr_hit,
    input logic          fp_reject
);

    localparam logic [XW-1:0] MOVE_WORD = {{(XW-NLET){1'b0}}, RD_MOVE};

    p_fd_pair_r4: assert property (@(posedge clk) disable iff (rst)
        !(!cur[L_F] && cur[L_D]));

    p_q_needs_fd_r5: assert property (@(posedge clk) disable iff (rst)
        cur[L_Q] |-> (cur[L_F] && cur[L_D]));

    p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(cur));

    p_reject_keeps_fp_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && fp_reject) |=> ($stable(cur[L_F]) && $stable(cur[L_D]) && $stable(cur[L_Q])));

    p_ro_bits_r2: assert property (@(posedge clk) disable iff (rst)
        (csr_addr == ISA_CSR_ADDR && $past(csr_addr) == ISA_CSR_ADDR) |->
        (((csr_rdata ^ $past(csr_rdata)) & ~MOVE_WORD) == '0));

    p_en_follows_r9: assert property (@(posedge clk) disable iff (rst)
        PRESENT |-> ((ext_en & ~bit_of(L_G)) == (cur & ~bit_of(L_G))));

    p_absent_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !PRESENT |-> (csr_rdata == '0));

endmodule

bind isa_caps_csr isa_caps_csr_chk #(.XW(XW), .PRESENT(PRESENT), .RD_MOVE(RD_MOVE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .csr_addr  (csr_addr),
    .csr_rdata (csr_rdata),
    .ext_en    (ext_en),
    .cur       (cur_bits),
    .wr_hit    (wr_hit),
    .fp_reject (fp_reject)
);

// File: tb/tb_isa_caps_csr.sv
module tb_isa_caps_csr;
    import isa_caps_pkg::*;

    localparam letter_vec_t IMPL_T = bit_of(L_A) | bit_of(L_C) | bit_of(L_D) | bit_of(L_F) |
                                     bit_of(L_I) | bit_of(L_M) | bit_of(L_Q) | bit_of(L_U);
    localparam letter_vec_t MUT_T  = bit_of(L_A) | bit_of(L_B) | bit_of(L_C) | bit_of(L_D) |
                                     bit_of(L_F) | bit_of(L_Q) | bit_of(L_V) | bit_of(L_G) |
                                     bit_of(L_I);
    // Implemented and mutable, excluding the summary and base bits.
    localparam letter_vec_t BM     = bit_of(L_A) | bit_of(L_C) | bit_of(L_D) | bit_of(L_F) |
                                     bit_of(L_Q);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] addr = ISA_CSR_ADDR;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] rdata_off;
    logic [63:0] rdata64;
    letter_vec_t en;
    letter_vec_t en_off;
    letter_vec_t en64;

    int n_run = 0;
    int n_fail = 0;
    letter_vec_t m;

    always #5 clk = ~clk;

    isa_caps_csr #(.XW(32), .PRESENT(1'b1), .IMPL_MASK(IMPL_T), .MUT_MASK(MUT_T)) dut (
        .clk(clk), .rst(rst), .csr_addr(addr), .csr_we(we), .csr_wdata(wdata),
        .csr_rdata(rdata), .ext_en(en));

    isa_caps_csr #(.XW(32), .PRESENT(1'b0), .IMPL_MASK(IMPL_T), .MUT_MASK(MUT_T)) dut_off (
        .clk(clk), .rst(rst), .csr_addr(addr), .csr_we(we), .csr_wdata(wdata),
        .csr_rdata(rdata_off), .ext_en(en_off));

    isa_caps_csr #(.XW(64), .PRESENT(1'b1), .IMPL_MASK(IMPL_T), .MUT_MASK(MUT_T)) dut64 (
        .clk(clk), .rst(rst), .csr_addr(addr), .csr_we(1'b0), .csr_wdata({32'hFFFF_FFFF, wdata}),
        .csr_rdata(rdata64), .ext_en(en64));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] view32(letter_vec_t v);
        return {2'b01, 4'b0000, fold_summary(v)};
    endfunction

    function automatic letter_vec_t scatter(int k);
        letter_vec_t v;
        v = '0;
        v[L_A] = k[0];
        v[L_C] = k[1];
        v[L_D] = k[2];
        v[L_F] = k[3];
        v[L_Q] = k[4];
        return v;
    endfunction

    // Expected next value from the rules: writable bits follow, illegal F/D/Q kept.
    function automatic letter_vec_t model_next(letter_vec_t old, letter_vec_t w, output logic bad);
        letter_vec_t c;
        c = (w & BM) | (old & ~BM);
        bad = (!c[L_F] && c[L_D]) || (c[L_Q] && !(c[L_F] && c[L_D]));
        if (bad) begin
            c[L_F] = old[L_F];
            c[L_D] = old[L_D];
            c[L_Q] = old[L_Q];
        end
        return c;
    endfunction

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a;
        wdata = d;
        we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        addr = ISA_CSR_ADDR;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic bad;
        logic [31:0] noise [4];
        noise[0] = 32'h0000_0000;
        noise[1] = 32'hFFFF_FFFF;
        noise[2] = 32'hAAAA_AAAA;
        noise[3] = 32'h5555_5555;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        m = IMPL_T;
        chk("R1 reset value", {32'd0, rdata}, {32'd0, view32(IMPL_T)});
        chk("R1 reset I bit", {63'd0, rdata[L_I]}, 64'd1);
        chk("R10 width code 64", {62'd0, rdata64[63:62]}, 64'd2);
        chk("R1 reset letters 64", {38'd0, rdata64[25:0]}, {38'd0, fold_summary(IMPL_T)});
        chk("R9 reset enables", {38'd0, en}, {38'd0, fold_summary(IMPL_T)});
        chk("R7 absent reads zero", {32'd0, rdata_off}, 64'd0);
        chk("R7 absent enables", {38'd0, en_off}, {38'd0, fold_summary(IMPL_T)});

        // Near-exhaustive sweep of the five writable bits under noise on all others.
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 32; k++) begin
                logic [31:0] w;
                w = (noise[p] & ~{6'd0, BM}) | {6'd0, scatter(k)};
                m = model_next(m, w[25:0], bad);
                do_write(ISA_CSR_ADDR, w);
                if (bad) chk("R4/R5 illegal fp write kept F D Q", {32'd0, rdata}, {32'd0, view32(m)});
                else     chk("R3 legal write value", {32'd0, rdata}, {32'd0, view32(m)});
                chk("R2 read-only bits", {32'd0, rdata & ~{6'd0, BM | bit_of(L_G)}},
                    {32'd0, view32(IMPL_T) & ~{6'd0, BM | bit_of(L_G)}});
                chk("R9 enables track bits", {38'd0, en}, {38'd0, fold_summary(m)});
                chk("R7 absent ignores write", {32'd0, rdata_off}, 64'd0);
            end
        end

        // R4 partial: other fields of a rejected write still land.
        m = model_next(m, BM, bad);
        do_write(ISA_CSR_ADDR, {6'd0, BM});
        m = model_next(m, bit_of(L_D) | bit_of(L_Q), bad);
        do_write(ISA_CSR_ADDR, {6'd0, bit_of(L_D) | bit_of(L_Q)});
        chk("R4 F cleared with D set rejected", {63'd0, rdata[L_F]}, 64'd1);
        chk("R4 A cleared in same write", {63'd0, rdata[L_A]}, 64'd0);
        m = model_next(m, bit_of(L_Q) | bit_of(L_F) | bit_of(L_C), bad);
        do_write(ISA_CSR_ADDR, {6'd0, bit_of(L_Q) | bit_of(L_F) | bit_of(L_C)});
        chk("R5 Q set with D clear rejected", {32'd0, rdata}, {32'd0, view32(m)});

        // R6 summary bit.
        m = model_next(m, BM, bad);
        do_write(ISA_CSR_ADDR, {6'd0, BM});
        chk("R6 G set when A M F D set", {63'd0, rdata[L_G]}, 64'd1);
        m = model_next(m, bit_of(L_G) | bit_of(L_D) | bit_of(L_F), bad);
        do_write(ISA_CSR_ADDR, {6'd0, bit_of(L_G) | bit_of(L_D) | bit_of(L_F)});
        chk("R6 G clear when A clear", {63'd0, rdata[L_G]}, 64'd0);
        chk("R9 A enable dropped", {63'd0, en[L_A]}, 64'd0);

        // R8 other address.
        do_write(12'h300, 32'h0000_0000);
        chk("R8 write elsewhere ignored", {32'd0, rdata}, {32'd0, view32(m)});
        @(negedge clk);
        addr = 12'h300;
        #1;
        chk("R8 read elsewhere zero", {32'd0, rdata}, 64'd0);
        addr = ISA_CSR_ADDR;
        #1;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule